// File: doc/BRIEF.md
# Three-Policy Peripheral-to-Memory DMA Controller

This block copies a run of bytes from a peripheral data port into a byte-addressable memory that shares its system bus with a host processor. Software first writes a base address and a 16-bit byte count. It then writes a control word that holds a bus-acquisition policy and a go bit. After a fixed setup period the controller moves the bytes one at a time. Each byte has an acknowledge cycle, in which the device byte is captured, and a write cycle, in which the byte is stored at the working address. The address steps up by one after every byte.

The bus is borrowed through a request/grant handshake, and the policy decides how. *Steal* asks for the bus once per byte and gives it back after that byte's write. *Burst* asks once and keeps the bus until the last byte, so the processor is held off for the whole block. *Hidden* captures the device byte without the bus and then writes only in cycles that the processor flags as bus-idle. In hidden mode the processor never loses a cycle. When the last byte is written, a sticky done flag is set and a single-cycle interrupt pulse is given.

The sequencer has the following states: IDLE, SETUP, SWAIT, REQ, HOLD, LATCH, WRITE, HWAIT, HSLOT and FINISH. Its transitions are:
- A start write moves any state to SETUP.
- SETUP runs for the setup period. It then goes to REQ in burst, to HWAIT in hidden, and to SWAIT otherwise.
- SWAIT goes to REQ when the device asks.
- REQ, on grant, goes to HOLD in burst and to LATCH in steal.
- HOLD goes to LATCH when the device asks and grant is present.
- LATCH goes to WRITE when the device asks and grant is present.
- WRITE, on grant, goes to FINISH on the last byte. Otherwise it goes to LATCH or HOLD in burst (LATCH when the device is asking) and to SWAIT in steal.
- HWAIT goes to HSLOT when the device asks.
- HSLOT, on an idle slot with grant, goes to FINISH on the last byte and to HWAIT otherwise.
- FINISH goes to IDLE.

Top module: `dma_mode_ctrl`

## Requirements
- R1: Register writes are selected by reg_sel: 0 loads the base address and 1 loads the byte count (low 16 bits). 2 is the control word, with bits [1:0] as the policy (0 steal, 1 burst, 2 hidden, 3 behaves as steal) and bit 2 as go. A control write with go set clears done in the next cycle and restarts from the stored base address and count, which stay in place across transfers.
- R2: No write strobe appears in the 21 cycles that follow the start edge: 20 setup cycles, then at least one handshake cycle.
- R3: mem_we is only ever high while both bus_req and bus_gnt are high, and mem_addr and mem_wdata read zero outside write cycles.
- R4: The k-th byte written goes to base address + k (counting from 0). Its value is the dev_data present in the cycle where dev_ack was high for that byte.
- R5: Exactly as many bytes are written as were programmed. A programmed count of 0 moves 65536 bytes.
- R6: In steal mode (and policy code 3), bus_req falls in the cycle after each write, so bus_req rises once per byte.
- R7: In burst mode, bus_req rises once per transfer, stays high until the last write, and is low in the cycle after it.
- R8: In hidden mode, bus_req and mem_we are high only in cycles where cpu_idle is high.
- R9: dev_ack is high only in cycles where dev_req is high.
- R10: After the last byte, xfer_irq is high for exactly one cycle and xfer_done goes high and stays high until the next start.
- R11: During and straight after reset, bus_req, mem_we, dev_ack, xfer_done and xfer_irq are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| reg_wdata | input | 32 | Register write data |
| dev_req | input | 1 | Peripheral has a byte ready |
| dev_data | input | 8 | Peripheral byte |
| dev_ack | output | 1 | Byte captured from peripheral this cycle |
| bus_req | output | 1 | Request for the system bus |
| bus_gnt | input | 1 | Bus granted by the host |
| cpu_idle | input | 1 | Processor marks this cycle as bus-idle |
| mem_addr | output | 32 | Memory byte address, valid with mem_we |
| mem_wdata | output | 8 | Memory write byte, valid with mem_we |
| mem_we | output | 1 | Memory write strobe |
| xfer_done | output | 1 | Sticky completion flag |
| xfer_irq | output | 1 | One-cycle completion pulse |

## Verification
The checks take for granted that the host keeps bus_gnt high for as long as bus_req is high. They also assume that the policy bits arrive in the same control write as the go bit, and that no register is written while a transfer is running. The bench makes grant follow request directly and issues register writes only while the controller is idle. Device requests are applied either continuously or with a gap pattern, so that the wait paths in SWAIT, HOLD, LATCH and HWAIT are exercised. Idle slots in hidden mode fall on every third cycle.

// File: rtl/dma_mode_pkg.sv
`timescale 1ns/1ps
package dma_mode_pkg;

    typedef enum logic [1:0] {
        XM_STEAL  = 2'd0,
        XM_BURST  = 2'd1,
        XM_HIDDEN = 2'd2,
        XM_ALT    = 2'd3
    } xfer_mode_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SWAIT,
        ST_REQ,
        ST_HOLD,
        ST_LATCH,
        ST_WRITE,
        ST_HWAIT,
        ST_HSLOT,
        ST_FINISH
    } dma_state_t;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;
    localparam int         GO_BIT    = 2;

endpackage

// File: rtl/dma_prog_regs.sv
`timescale 1ns/1ps
module dma_prog_regs
    import dma_mode_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_sel,
    input  logic [AW-1:0]    reg_wdata,
    output logic [AW-1:0]    base_addr,
    output logic [CW-1:0]    base_cnt,
    output logic             start,
    output xfer_mode_t       start_mode
);

    logic ctrl_wr;

    assign ctrl_wr = reg_we && (reg_sel == SEL_CTRL);
    assign start   = ctrl_wr && reg_wdata[GO_BIT];

    always_comb begin
        unique case (reg_wdata[1:0])
            2'd1:    start_mode = XM_BURST;
            2'd2:    start_mode = XM_HIDDEN;
            default: start_mode = XM_STEAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_addr <= '0;
            base_cnt  <= '0;
        end else if (reg_we) begin
            if (reg_sel == SEL_ADDR)
                base_addr <= reg_wdata;
            if (reg_sel == SEL_COUNT)
                base_cnt <= reg_wdata[CW-1:0];
        end
    end

endmodule

// File: rtl/dma_xfer_path.sv
`timescale 1ns/1ps
module dma_xfer_path #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] base_cnt,
    input  logic          ack,
    input  logic [DW-1:0] dev_data,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data,
    output logic          last
);

    localparam int RW = CW + 1;
    localparam logic [RW-1:0] FULL_BLOCK = RW'(1) << CW;

    logic [AW-1:0] addr_q;
    logic [RW-1:0] remain_q;
    logic [DW-1:0] data_q;
    logic [RW-1:0] load_cnt;

    assign load_cnt = (base_cnt == '0) ? FULL_BLOCK : {1'b0, base_cnt};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
        end else if (load) begin
            addr_q   <= base_addr;
            remain_q <= load_cnt;
        end else if (step) begin
            addr_q   <= addr_q + 1'b1;
            remain_q <= remain_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            data_q <= '0;
        else if (ack)
            data_q <= dev_data;
    end

    assign addr = addr_q;
    assign data = data_q;
    assign last = (remain_q == RW'(1));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (addr_q == $past(addr_q) + 1'b1));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (remain_q != '0));

endmodule

// File: rtl/dma_seq_fsm.sv
`timescale 1ns/1ps
module dma_seq_fsm
    import dma_mode_pkg::*;
#(
    parameter int SETUP_CYC = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  xfer_mode_t  start_mode,
    input  logic        dev_req,
    input  logic        bus_gnt,
    input  logic        cpu_idle,
    input  logic        last,
    output logic        load,
    output logic        dev_ack,
    output logic        bus_req,
    output logic        mem_we,
    output logic        xfer_done,
    output logic        xfer_irq
);

    localparam int TW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
    localparam int SW = $clog2(SETUP_CYC + 2);
    localparam logic [SW-1:0] SAT = SW'(SETUP_CYC + 1);

    dma_state_t state_q, state_d;
    xfer_mode_t mode_q;
    logic [TW-1:0] tmr_q;
    logic done_q;
    logic [SW-1:0] since_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_IDLE;
            ST_SETUP: begin
                if (tmr_q == '0) begin
                    if (mode_q == XM_BURST)
                        state_d = ST_REQ;
                    else if (mode_q == XM_HIDDEN)
                        state_d = ST_HWAIT;
                    else
                        state_d = ST_SWAIT;
                end
            end
            ST_SWAIT:  if (dev_req) state_d = ST_REQ;
            ST_REQ: begin
                if (bus_gnt)
                    state_d = (mode_q == XM_BURST) ? ST_HOLD : ST_LATCH;
            end
            ST_HOLD:   if (dev_req && bus_gnt) state_d = ST_LATCH;
            ST_LATCH:  if (dev_req && bus_gnt) state_d = ST_WRITE;
            ST_WRITE: begin
                if (bus_gnt) begin
                    if (last)
                        state_d = ST_FINISH;
                    else if (mode_q == XM_BURST)
                        state_d = dev_req ? ST_LATCH : ST_HOLD;
                    else
                        state_d = ST_SWAIT;
                end
            end
            ST_HWAIT:  if (dev_req) state_d = ST_HSLOT;
            ST_HSLOT: begin
                if (cpu_idle && bus_gnt)
                    state_d = last ? ST_FINISH : ST_HWAIT;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
        if (start)
            state_d = ST_SETUP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= XM_STEAL;
            tmr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start) begin
                mode_q <= start_mode;
                tmr_q  <= TW'(SETUP_CYC - 1);
                done_q <= 1'b0;
            end else begin
                if (state_q == ST_SETUP && tmr_q != '0)
                    tmr_q <= tmr_q - 1'b1;
                if (state_q == ST_FINISH)
                    done_q <= 1'b1;
            end
        end
    end

    always_comb begin
        dev_ack  = 1'b0;
        bus_req  = 1'b0;
        mem_we   = 1'b0;
        xfer_irq = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SETUP, ST_SWAIT: ;
            ST_REQ, ST_HOLD: bus_req = 1'b1;
            ST_LATCH: begin
                bus_req = 1'b1;
                dev_ack = dev_req && bus_gnt;
            end
            ST_WRITE: begin
                bus_req = 1'b1;
                mem_we  = bus_gnt;
            end
            ST_HWAIT:  dev_ack = dev_req;
            ST_HSLOT: begin
                bus_req = cpu_idle;
                mem_we  = cpu_idle && bus_gnt;
            end
            ST_FINISH: xfer_irq = 1'b1;
            default: ;
        endcase
    end

    assign load      = start;
    assign xfer_done = done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_q <= '0;
        else if (start)
            since_q <= '0;
        else if (since_q != SAT)
            since_q <= since_q + 1'b1;
    end

    // R2
    setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (since_q == SAT));

    // R6
    steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mode_q != XM_BURST) |=> !bus_req);

    // R7
    burst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && last) |=> !bus_req);

    // R7
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_BURST && $fell(bus_req)) |-> ($past(mem_we && last) || $past(start)));

    // R8
    hidden_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == XM_HIDDEN && (bus_req || mem_we)) |-> cpu_idle);

    // R9
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> dev_req);

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_irq |=> (!xfer_irq && xfer_done));

endmodule

// File: rtl/dma_mode_ctrl.sv
`timescale 1ns/1ps
module dma_mode_ctrl
    import dma_mode_pkg::*;
#(
    parameter int AW        = 32,
    parameter int CW        = 16,
    parameter int DW        = 8,
    parameter int SETUP_CYC = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_sel,
    input  logic [AW-1:0] reg_wdata,
    input  logic          dev_req,
    input  logic [DW-1:0] dev_data,
    output logic          dev_ack,
    output logic          bus_req,
    input  logic          bus_gnt,
    input  logic          cpu_idle,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          xfer_done,
    output logic          xfer_irq
);

    logic [AW-1:0] base_addr;
    logic [CW-1:0] base_cnt;
    logic          start;
    xfer_mode_t    start_mode;
    logic          load;
    logic          last;
    logic [AW-1:0] work_addr;
    logic [DW-1:0] work_data;

    dma_prog_regs #(.AW(AW), .CW(CW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .base_addr  (base_addr),
        .base_cnt   (base_cnt),
        .start      (start),
        .start_mode (start_mode)
    );

    dma_xfer_path #(.AW(AW), .CW(CW), .DW(DW)) path_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base_addr (base_addr),
        .base_cnt  (base_cnt),
        .ack       (dev_ack),
        .dev_data  (dev_data),
        .step      (mem_we),
        .addr      (work_addr),
        .data      (work_data),
        .last      (last)
    );

    dma_seq_fsm #(.SETUP_CYC(SETUP_CYC)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_mode (start_mode),
        .dev_req    (dev_req),
        .bus_gnt    (bus_gnt),
        .cpu_idle   (cpu_idle),
        .last       (last),
        .load       (load),
        .dev_ack    (dev_ack),
        .bus_req    (bus_req),
        .mem_we     (mem_we),
        .xfer_done  (xfer_done),
        .xfer_irq   (xfer_irq)
    );

    assign mem_addr  = mem_we ? work_addr : '0;
    assign mem_wdata = mem_we ? work_data : '0;

    // R3
    bus_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bus_req && bus_gnt));

endmodule

// File: tb/dma_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_mode_ctrl_tb_top;

    localparam int AW = 32;
    localparam int SETUP = 20;
    localparam int LIMIT = 190000;

    // {mode[1:0], gap, addr[31:0], count[15:0]}
    localparam int NV = 8;
    localparam logic [50:0] VEC [NV] = '{
        {2'd0, 1'b0, 32'h0000_1000, 16'd5},
        {2'd0, 1'b1, 32'h0000_20FE, 16'd9},
        {2'd1, 1'b0, 32'h0000_3000, 16'd16},
        {2'd1, 1'b1, 32'h0000_4FFF, 16'd7},
        {2'd2, 1'b0, 32'h0000_5000, 16'd6},
        {2'd2, 1'b1, 32'h0000_6000, 16'd11},
        {2'd3, 1'b0, 32'h0000_7000, 16'd3},
        {2'd1, 1'b0, 32'h0000_8000, 16'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [AW-1:0] reg_wdata = '0;
    logic dev_req = 1'b0;
    logic [7:0] dev_data = 8'd0;
    logic cpu_idle = 1'b0;
    logic host_ok = 1'b1;
    logic dev_ack, bus_req, bus_gnt, mem_we, xfer_done, xfer_irq;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata;

    assign bus_gnt = bus_req & host_ok;

    dma_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dev_req(dev_req), .dev_data(dev_data),
        .dev_ack(dev_ack), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .cpu_idle(cpu_idle), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .xfer_done(xfer_done), .xfer_irq(xfer_irq)
    );

    always #2 clk = ~clk;

    int total = 0, bad = 0;
    int gcyc = 0;
    bit gap_en = 0, hid_run = 0;
    int nwr, first_wr, addr_err, data_err, ack_err, hs_err, hid_err, rises, irqs;
    logic [AW-1:0] exp_addr;
    logic [7:0] held;
    logic req_prev = 1'b0;

    function automatic logic [7:0] pat(input int g);
        logic [31:0] u;
        u = 32'(g);
        return u[7:0] ^ 8'h3C ^ {u[10:8], 5'b0};
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // input generator and monitor share one process
    initial begin
        forever begin
            @(negedge clk);
            gcyc++;
            dev_req  = gap_en ? (gcyc % 8 >= 3) : 1'b1;
            cpu_idle = (gcyc % 3 == 0);
            dev_data = pat(gcyc);
            #1;
            if (mem_we) begin
                if (nwr == 0) first_wr = gcyc;
                if (mem_addr != exp_addr) addr_err++;
                if (mem_wdata != held) data_err++;
                exp_addr = exp_addr + 1;
                nwr++;
            end
            if (dev_ack) begin
                held = dev_data;
                if (!dev_req) ack_err++;
            end
            if (bus_req && !req_prev) rises++;
            req_prev = bus_req;
            if (mem_we && !(bus_req && bus_gnt)) hs_err++;
            if (hid_run && (mem_we || bus_req) && !cpu_idle) hid_err++;
            if (xfer_irq) irqs++;
            if (gcyc > LIMIT) begin
                chk(1'b0, "R10 watchdog, done never seen", 0, 1);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        @(negedge clk); #1.5;
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk); #1.5;
        reg_we = 1'b0;
    endtask

    task automatic clear_mon(input logic [AW-1:0] a);
        nwr = 0; first_wr = 0; addr_err = 0; data_err = 0; ack_err = 0;
        hs_err = 0; hid_err = 0; rises = 0; irqs = 0; exp_addr = a;
    endtask

    task automatic go_and_wait(input logic [1:0] mode, input logic [AW-1:0] a,
                               input int eff, input string nm);
        int st;
        clear_mon(a);
        @(negedge clk); #1.5;
        reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = 32'(mode) | 32'h4;
        st = gcyc;
        @(negedge clk); #1.5;
        reg_we = 1'b0;
        chk(xfer_done == 1'b0, {"R1 done cleared by start ", nm}, xfer_done, 0);
        while (!xfer_done) begin
            @(negedge clk); #1.5;
        end
        repeat (3) begin
            @(negedge clk); #1.5;
        end
        chk(nwr == eff, {"R5 byte count ", nm}, nwr, eff);
        chk(addr_err == 0, {"R4 address sequence ", nm}, addr_err, 0);
        chk(data_err == 0, {"R4 data value ", nm}, data_err, 0);
        chk(first_wr - st >= SETUP + 2, {"R2 setup gap ", nm}, first_wr - st, SETUP + 2);
        chk(irqs == 1, {"R10 irq pulses ", nm}, irqs, 1);
        chk(xfer_done == 1'b1, {"R10 done set ", nm}, xfer_done, 1);
        chk(hs_err == 0, {"R3 write without grant ", nm}, hs_err, 0);
        chk(ack_err == 0, {"R9 ack without request ", nm}, ack_err, 0);
        if (mode == 2'd1)
            chk(rises == 1, {"R7 burst request rises ", nm}, rises, 1);
        else if (mode == 2'd2)
            chk(hid_err == 0, {"R8 hidden outside idle ", nm}, hid_err, 0);
        else
            chk(rises == eff, {"R6 steal request rises ", nm}, rises, eff);
    endtask

    task automatic run(input logic [1:0] mode, input bit gap, input logic [AW-1:0] a,
                       input logic [15:0] cnt, input string nm);
        int eff;
        eff = (cnt == 16'd0) ? 65536 : int'(cnt);
        gap_en = gap;
        hid_run = (mode == 2'd2);
        wr(2'd0, a);
        wr(2'd1, 32'(cnt));
        go_and_wait(mode, a, eff, nm);
    endtask

    initial begin
        clear_mon('0);
        repeat (4) @(negedge clk);
        #1.5;
        // R11 reset state
        chk(bus_req == 0 && mem_we == 0 && dev_ack == 0, "R11 bus idle in reset", bus_req, 0);
        chk(xfer_done == 0 && xfer_irq == 0, "R11 flags low in reset", xfer_done, 0);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk); #1.5;
        end
        chk(bus_req == 0 && mem_we == 0 && xfer_done == 0, "R11 idle after reset", bus_req, 0);

        for (int i = 0; i < NV; i++) begin
            run(VEC[i][50:49], VEC[i][48], VEC[i][47:16], VEC[i][15:0],
                $sformatf("vec%0d", i));
        end

        // R10 done sticky, no extra pulse
        repeat (40) begin
            @(negedge clk); #1.5;
        end
        chk(xfer_done == 1'b1, "R10 done stays set", xfer_done, 1);
        chk(irqs == 1, "R10 no second pulse", irqs, 1);

        // R1 restart reuses stored base address and count (last programmed: 0x8000, 1)
        gap_en = 0; hid_run = 0;
        go_and_wait(2'd0, 32'h0000_8000, 1, "restart");

        // R1 select 3 is ignored: stored values unchanged
        wr(2'd3, 32'h0000_9999);
        go_and_wait(2'd1, 32'h0000_8000, 1, "sel3");

        // R5 zero count means full block
        run(2'd1, 1'b0, 32'h0001_0000, 16'd0, "count0");
        chk(exp_addr == 32'h0002_0000, "R5 final address after full block", exp_addr, 32'h0002_0000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule